// File: doc/BRIEF.md
# Receive Built-In Self-Test Pattern Checker

This block sits after the receive decoder and checks a pseudo-random test stream during built-in self-test. The stream is 511 symbols long and repeats. Each symbol is nine bits: a data/special flag and a byte. When the test enable is raised, the checker waits for the loop start symbol. This is a data symbol with byte 0x00. When that symbol arrives, the checker seeds a 9-bit maximal-length shift register. From then on, every valid decoded symbol is compared with the symbol the register predicts.

A mismatch raises the error output for one cycle. Code violations and disparity errors are not reported while the test is enabled, because the test pattern contains deliberate violation symbols. A progress pulse marks each point where a full loop of the pattern has been checked. The only way to restart the checker is to drop the test enable and raise it again. When the test is off, the error output reports the decoder's code and disparity errors instead.

Top module: `rx_bist_checker`

## Requirements
- R1: After reset, err_flag, loop_pulse and bist_running are all low.
- R2: With bist_en low, err_flag equals sym_valid AND (code_viol OR disp_err) of the previous clock cycle, and loop_pulse stays low.
- R3: With bist_en high and no loop started, err_flag and loop_pulse stay low. Any symbol other than flag 0 with byte 0x00 leaves the checker waiting; this includes flag 1 with byte 0x00.
- R4: A valid symbol with flag 0 and byte 0x00, received while waiting, starts the loop. bist_running is high from the next cycle.
- R5: The register state s steps to {s[7:0], s[8]^s[4]}. The expected symbol {flag, byte} is s XOR LOOP_MARK (default 9'h1A7). At start, the register is loaded with the step of LOOP_MARK. The symbol at LOOP_MARK is therefore 0x000, the start code, once per 511 symbols.
- R6: While running, err_flag is high in the cycle after a valid symbol that differs from the expected symbol, and low after a symbol that matches.
- R7: While bist_en is high, code_viol and disp_err have no effect on err_flag.
- R8: The register advances exactly once per valid symbol while running. A cycle with sym_valid low leaves it unchanged and gives low err_flag and loop_pulse in the next cycle.
- R9: loop_pulse is high for one cycle after each valid symbol checked at register state LOOP_MARK, which is every 511th symbol after the start.
- R10: While running, a start code does not reseed the register. Only a low level on bist_en followed by a high level re-arms the wait for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_en | input | 1 | Self-test enable |
| sym_valid | input | 1 | Decoded symbol strobe |
| sym_special | input | 1 | Symbol is a special code (1) or data (0) |
| sym_data | input | 8 | Decoded symbol byte |
| code_viol | input | 1 | Decoder code-rule violation |
| disp_err | input | 1 | Decoder running disparity error |
| err_flag | output | 1 | Error: mismatch while testing, decoder error otherwise |
| loop_pulse | output | 1 | One-cycle pulse per completed pattern loop |
| bist_running | output | 1 | Loop started and checker synchronized |

## Verification
The assertions assume a few things about the inputs. The symbol fields are meaningful only when sym_valid is high. bist_en may change in any cycle, and the checker treats its level in a cycle as the mode for that cycle. The stimulus drives random symbols, random decoder error flags and random gaps in sym_valid. After the loop has started, it sends mostly the correct expected sequence, with occasional injected single-bit mismatches and stray start codes. Each bist_en toggle is held for at least one cycle at each level, so the wait state is always entered before a start code arrives.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W = 8;
  localparam int SYM_W  = DATA_W + 1;
  localparam int TAP_HI = SYM_W - 1;
  localparam int TAP_LO = 4;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  // Fibonacci step for x^9 + x^5 + 1
  function automatic sym_t lfsr_step(input sym_t s);
    return {s[SYM_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  // Expected {flag, byte} for a register state
  function automatic sym_t expect_sym(input sym_t s, input sym_t mark);
    return s ^ mark;
  endfunction

  function automatic logic is_start(input sym_t s);
    return s == '0;
  endfunction
endpackage

// File: rtl/rxb_phase.sv
module rxb_phase
  import rxb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bist_en,
  input  logic sym_valid,
  input  sym_t rx_sym,
  output logic start_hit,
  output logic running
);
  phase_t phase;

  assign start_hit = bist_en && sym_valid && (phase == PH_WAIT) && is_start(rx_sym);
  assign running   = (phase == PH_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else if (!bist_en) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: phase <= PH_WAIT;
        PH_WAIT: if (start_hit) phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  // R10: once running, only leaving test mode drops the loop
  assert_hold_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bist_en) |=> running);
  // R10: leaving test mode always returns to idle
  assert_leave_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> (!running && !start_hit));
  // R4: a start code while waiting starts the loop
  assert_start_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> running);
endmodule

// File: rtl/rxb_lfsr.sv
module rxb_lfsr
  import rxb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  sym_t seed,
  output sym_t state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= sym_t'(1);
    else if (load) state <= seed;
    else if (adv)  state <= lfsr_step(state);
  end

  // R5: loading a seed yields that seed
  assert_load_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == $past(seed)));
endmodule

// File: rtl/rxb_cmp.sv
module rxb_cmp
  import rxb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bist_en,
  input  logic running,
  input  logic sym_valid,
  input  sym_t rx_sym,
  input  sym_t exp_sym,
  input  logic at_mark,
  input  logic code_viol,
  input  logic disp_err,
  output logic err_flag,
  output logic loop_pulse
);
  logic chk;
  logic miss;
  logic err_nxt;

  assign chk     = bist_en && running && sym_valid;
  assign miss    = (rx_sym != exp_sym);
  assign err_nxt = bist_en ? (chk && miss) : (sym_valid && (code_viol || disp_err));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag   <= 1'b0;
      loop_pulse <= 1'b0;
    end else begin
      err_flag   <= err_nxt;
      loop_pulse <= chk && at_mark;
    end
  end

  // R3: no error reported while waiting for the start code
  assert_quiet_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && !running) |=> (!err_flag && !loop_pulse));
  // R8: an idle cycle produces no error and no pulse
  assert_gap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> (!err_flag && !loop_pulse));
  // R9: no progress pulse outside test mode
  assert_pulse_bist_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> !loop_pulse);
  // R7: decoder errors do not show on a matching symbol in test mode
  assert_ignore_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && (rx_sym == exp_sym) && (code_viol || disp_err)) |=> !err_flag);
endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker
  import rxb_pkg::*;
#(
  parameter sym_t LOOP_MARK = 9'h1A7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              sym_valid,
  input  logic              sym_special,
  input  logic [DATA_W-1:0] sym_data,
  input  logic              code_viol,
  input  logic              disp_err,
  output logic              err_flag,
  output logic              loop_pulse,
  output logic              bist_running
);
  sym_t rx_sym;
  sym_t lfsr_state;
  sym_t exp_sym;
  sym_t seed;
  logic start_hit;
  logic running;
  logic adv;
  logic at_mark;

  assign rx_sym       = {sym_special, sym_data};
  assign seed         = lfsr_step(LOOP_MARK);
  assign adv          = bist_en && running && sym_valid;
  assign at_mark      = (lfsr_state == LOOP_MARK);
  assign exp_sym      = expect_sym(lfsr_state, LOOP_MARK);
  assign bist_running = running;

  rxb_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .bist_en   (bist_en),
    .sym_valid (sym_valid),
    .rx_sym    (rx_sym),
    .start_hit (start_hit),
    .running   (running)
  );

  rxb_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_hit),
    .adv   (adv),
    .seed  (seed),
    .state (lfsr_state)
  );

  rxb_cmp u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .bist_en    (bist_en),
    .running    (running),
    .sym_valid  (sym_valid),
    .rx_sym     (rx_sym),
    .exp_sym    (exp_sym),
    .at_mark    (at_mark),
    .code_viol  (code_viol),
    .disp_err   (disp_err),
    .err_flag   (err_flag),
    .loop_pulse (loop_pulse)
  );

  // R8: register holds across idle cycles while running
  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && running && !sym_valid) |=> $stable(lfsr_state));
  // R8: register steps once per valid symbol while running
  assert_lfsr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (lfsr_state != $past(lfsr_state)));
  // R5: the register never sits in the all-zero lock state while running
  assert_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (lfsr_state != '0));
  // R10: a start code while running does not reseed
  assert_no_reseed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rx_sym == '0 && !at_mark) |=> (lfsr_state != seed));
endmodule

// File: tb/rx_bist_checker_test.sv
module rx_bist_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] MARK = 9'h1A7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bist_en, sym_valid, sym_special, code_viol, disp_err;
  logic [7:0] sym_data;
  logic       err_flag, loop_pulse, bist_running;

  int checks = 0;
  int errors = 0;
  int pulses = 0;

  // bench model: 0 idle, 1 waiting, 2 running
  int         m_mode = 0;
  logic [8:0] m_lfsr = 9'h001;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bist_checker uut (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .sym_valid(sym_valid),
    .sym_special(sym_special), .sym_data(sym_data), .code_viol(code_viol),
    .disp_err(disp_err), .err_flag(err_flag), .loop_pulse(loop_pulse),
    .bist_running(bist_running)
  );

  function automatic logic [8:0] b_next(input logic [8:0] s);
    logic fb;
    fb = s[8] ^ s[4];
    return (s << 1) | {8'd0, fb};
  endfunction

  function automatic logic [8:0] b_expect();
    return m_lfsr ^ MARK;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic v, input logic [8:0] s,
                      input logic cv, input logic de, input string tag);
    logic e_err, e_pulse;
    e_err = 1'b0;
    e_pulse = 1'b0;
    if (!b) begin
      e_err = v & (cv | de);
      m_mode = 0;
    end else if (m_mode == 0) begin
      m_mode = 1;
    end else if (m_mode == 1) begin
      if (v && s == 9'h000) begin
        m_mode = 2;
        m_lfsr = b_next(MARK);
      end
    end else if (v) begin
      e_err = (s != b_expect());
      e_pulse = (m_lfsr == MARK);
      m_lfsr = b_next(m_lfsr);
    end
    bist_en = b; sym_valid = v; {sym_special, sym_data} = s;
    code_viol = cv; disp_err = de;
    @(posedge clk);
    @(negedge clk);
    check(tag, "err_flag", err_flag, e_err);
    check("R9", "loop_pulse", loop_pulse, e_pulse);
    check("R4", "bist_running", bist_running, m_mode == 2);
    if (loop_pulse) pulses++;
  endtask

  task automatic run_loop(input int n, input int err_pct);
    for (int i = 0; i < n; i++) begin
      logic v;
      logic [8:0] s;
      logic cv, de;
      v = ($urandom % 5) != 0;
      cv = $urandom % 2;
      de = $urandom % 2;
      s = b_expect();
      if (!v) begin
        step(1'b1, 1'b0, 9'($urandom), cv, de, "R8");
      end else if (($urandom % 100) < err_pct) begin
        s = s ^ (9'd1 << ($urandom % 9));
        step(1'b1, 1'b1, s, cv, de, "R6");
      end else begin
        step(1'b1, 1'b1, s, cv, de, (cv | de) ? "R7" : "R5");
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4711);
    rst_n = 1'b0; bist_en = 0; sym_valid = 0; sym_special = 0;
    sym_data = 0; code_viol = 0; disp_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "err_flag", err_flag, 1'b0);
    check("R1", "loop_pulse", loop_pulse, 1'b0);
    check("R1", "bist_running", bist_running, 1'b0);

    // test off: decoder errors reported
    for (int i = 0; i < 40; i++)
      step(1'b0, 1'($urandom), 9'($urandom), 1'($urandom), 1'($urandom), "R2");

    // test on, waiting: noise and special 0x00 do not start
    step(1'b1, 1'b1, 9'h100, 1'b1, 1'b1, "R3");
    step(1'b1, 1'b1, 9'h100, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, 9'h000, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 40; i++) begin
      logic [8:0] s;
      s = 9'($urandom);
      if (s == 9'h000) s = 9'h100;
      step(1'b1, 1'($urandom), s, 1'($urandom), 1'($urandom), "R3");
    end

    // start code
    step(1'b1, 1'b1, 9'h000, 1'b1, 1'b0, "R4");

    // full loops with gaps, violations and injected mismatches
    pulses = 0;
    run_loop(1400, 4);
    checks++;
    if (pulses < 2) begin
      errors++;
      $display("FAIL R9 pulse_count actual=%0d expected>=2", pulses);
    end

    // stray start code while running must not reseed
    while (b_expect() == 9'h000) step(1'b1, 1'b1, b_expect(), 1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, 9'h000, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b1, b_expect(), 1'b0, 1'b0, "R10");
    step(1'b1, 1'b1, b_expect(), 1'b1, 1'b1, "R10");

    // re-arm by toggling the enable
    step(1'b0, 1'b1, 9'h000, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b0, 9'h000, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b1, 9'h000, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b1, 9'h055, 1'b0, 1'b1, "R3");
    step(1'b1, 1'b1, 9'h000, 1'b0, 1'b0, "R10");
    run_loop(600, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule